// File: doc/BRIEF.md
# Selectable Power-of-Two Clock Divider

This block receives a single clock and produces a configurable number of complementary output pairs, two by default. Every pair carries the same waveform: the input clock itself, or the input divided by 2, 4, 8 or 16. A three-bit select code picks the source. An active-low reset parks every pair in a disabled state, with the true leg low and the complement leg high.

When reset is released, the enable is re-timed on a falling edge of the input clock. The divider always restarts from the same phase, and the first output pulse is never shortened. The select code is captured only while the block is disabled. A new ratio therefore takes effect through a reset cycle, and no switching glitch can appear on a running output.

Top module: `pow2_clk_divider`

## Requirements
- R1: With select bit 2 at 0, every true output follows the input clock one-for-one, and select bits 1 and 0 have no effect.
- R2: With select bit 2 at 1, select bits 1:0 set the division ratio: 00 gives 2, 01 gives 4, 10 gives 8 and 11 gives 16. Each divided output is high for half its period and low for the other half.
- R3: While reset is 0, every true output is 0 and every complement output is 1 for all select codes. This takes hold at once, including when reset is asserted mid-run.
- R4: Reset clears the divider phase. Counting n from 0 at the first input rising edge after the enable takes hold, a divided output at ratio D is high when floor(n/(D/2)) is even.
- R5: Releasing reset takes effect at the next falling edge of the input. Until then all true outputs stay 0, so the first output high phase is a full input high phase.
- R6: All output pairs carry identical waveforms.
- R7: Each complement output is the exact inverse of its true output at every moment.
- R8: The select code is sampled only while the block is disabled. A change of select while running has no effect until the next reset cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be buffered or divided |
| rst_n | input | 1 | Active-low reset; holds outputs disabled and clears the divider; tie high in the system when unused |
| sel | input | 3 | Source select: bit 2 = 0 gives pass-through, bit 2 = 1 gives division by 2^(bits 1:0 + 1); tie high for divide by 16 |
| out_true | output | 2 | True leg of each output pair |
| out_comp | output | 2 | Complement leg of each output pair |

## Verification
The hardest window to reach is the half-cycle between reset release and the falling edge that re-times the enable. Only in that window can a truncated first pulse appear in pass-through mode. The stimulus releases reset just after an input rising edge and samples the outputs while the input is still high, before that falling edge. A second hard case is a select change on a running output. This is reached by altering the select mid-run in divide-by-2 mode and confirming that the old toggle pattern continues, then applying the new code through a reset cycle.

// File: rtl/pow2div_pkg.sv
package pow2div_pkg;
   // Source of the output pairs, encoded as the select MSB
   typedef enum logic {
      SRC_BYPASS  = 1'b0,
      SRC_DIVIDED = 1'b1
   } src_mode_e;
endpackage

// File: rtl/pow2div_enable.sv
module pow2div_enable #(
   parameter int SEL_W = 3
) (
   input  logic             clk_in,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel_in,
   output logic             en_q,
   output logic [SEL_W-1:0] sel_q
);
   // Enable re-timed on the falling edge so the first high phase is whole
   always_ff @(negedge clk_in or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= 1'b1;
   end

   // Select follows the pins only while disabled, frozen once running
   always_ff @(negedge clk_in) begin
      if (!en_q) sel_q <= sel_in;
   end
endmodule

// File: rtl/pow2div_counter.sv
module pow2div_counter #(
   parameter int CNT_W = 4
) (
   input  logic             clk_in,
   input  logic             rst_n,
   input  logic             en_q,
   output logic [CNT_W-1:0] cnt_q
);
   // Parked at all ones so the first enabled edge lands on zero
   always_ff @(posedge clk_in or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '1;
      else if (!en_q) cnt_q <= '1;
      else            cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/pow2div_select.sv
module pow2div_select
   import pow2div_pkg::*;
#(
   parameter int RATIO_BITS = 2,
   localparam int CNT_W = 1 << RATIO_BITS,
   localparam int SEL_W = RATIO_BITS + 1
) (
   input  logic             clk_in,
   input  logic             en_q,
   input  logic [SEL_W-1:0] sel_q,
   input  logic [CNT_W-1:0] cnt_q,
   output logic             src_o
);
   logic [CNT_W-1:0] taps;
   src_mode_e        mode;

   for (genvar t = 0; t < CNT_W; t++) begin : g_tap
      // Inverted counter bit: high for the first half of each period
      assign taps[t] = ~cnt_q[t];
   end

   assign mode = src_mode_e'(sel_q[SEL_W-1]);

   always_comb begin
      if (mode == SRC_DIVIDED) src_o = taps[sel_q[RATIO_BITS-1:0]];
      else                     src_o = clk_in & en_q;
   end
endmodule

// File: rtl/pow2div_drive.sv
module pow2div_drive #(
   parameter int NUM_PAIRS = 2
) (
   input  logic                 src_i,
   output logic [NUM_PAIRS-1:0] out_true,
   output logic [NUM_PAIRS-1:0] out_comp
);
   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      assign out_true[p] = src_i;
      assign out_comp[p] = ~src_i;
   end
endmodule

// File: rtl/pow2_clk_divider.sv
module pow2_clk_divider #(
   parameter int NUM_PAIRS  = 2,
   parameter int RATIO_BITS = 2,
   localparam int SEL_W = RATIO_BITS + 1,
   localparam int CNT_W = 1 << RATIO_BITS
) (
   input  logic                 clk_in,
   input  logic                 rst_n,
   input  logic [SEL_W-1:0]     sel,
   output logic [NUM_PAIRS-1:0] out_true,
   output logic [NUM_PAIRS-1:0] out_comp
);
   initial begin
      assert (NUM_PAIRS >= 1) else $error("NUM_PAIRS must be at least 1");
      assert (RATIO_BITS >= 1 && RATIO_BITS <= 4) else $error("RATIO_BITS out of range");
   end

   logic             en_q;
   logic [SEL_W-1:0] sel_q;
   logic [CNT_W-1:0] cnt_q;
   logic             src;

   pow2div_enable #(.SEL_W(SEL_W)) u_enable (
      .clk_in(clk_in), .rst_n(rst_n), .sel_in(sel), .en_q(en_q), .sel_q(sel_q)
   );

   pow2div_counter #(.CNT_W(CNT_W)) u_counter (
      .clk_in(clk_in), .rst_n(rst_n), .en_q(en_q), .cnt_q(cnt_q)
   );

   pow2div_select #(.RATIO_BITS(RATIO_BITS)) u_select (
      .clk_in(clk_in), .en_q(en_q), .sel_q(sel_q), .cnt_q(cnt_q), .src_o(src)
   );

   pow2div_drive #(.NUM_PAIRS(NUM_PAIRS)) u_drive (
      .src_i(src), .out_true(out_true), .out_comp(out_comp)
   );
endmodule

// File: rtl/pow2_clk_divider_chk.sv
module pow2_clk_divider_chk #(
   parameter int NUM_PAIRS  = 2,
   parameter int RATIO_BITS = 2,
   localparam int SEL_W = RATIO_BITS + 1,
   localparam int CNT_W = 1 << RATIO_BITS
) (
   input logic                 clk_in,
   input logic                 rst_n,
   input logic                 en_q,
   input logic [SEL_W-1:0]     sel_q,
   input logic [CNT_W-1:0]     cnt_q,
   input logic [NUM_PAIRS-1:0] out_true
);
   // R8
   sel_frozen_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
      (en_q && $past(en_q)) |-> $stable(sel_q));

   // R5
   quiet_until_enable_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
      !en_q |-> (out_true == '0));

   // R4
   phase_restart_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
      $rose(en_q) |-> (cnt_q == '1));

   // R2
   half_rate_toggle_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
      (en_q && $past(en_q) && sel_q == {1'b1, {RATIO_BITS{1'b0}}})
      |-> (out_true[0] != $past(out_true[0])));

   // R1
   bypass_low_before_edge_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
      (en_q && !sel_q[SEL_W-1]) |-> (out_true == '0));
endmodule

bind pow2_clk_divider pow2_clk_divider_chk #(
   .NUM_PAIRS(NUM_PAIRS), .RATIO_BITS(RATIO_BITS)
) u_chk (
   .clk_in(clk_in), .rst_n(rst_n), .en_q(en_q), .sel_q(sel_q),
   .cnt_q(cnt_q), .out_true(out_true)
);

// File: tb/pow2_clk_divider_test.sv
module pow2_clk_divider_test;
   localparam int NP = 2;

   logic          clk_in = 1'b0;
   logic          rst_n  = 1'b0;
   logic [2:0]    sel    = 3'b111;
   logic [NP-1:0] out_true;
   logic [NP-1:0] out_comp;

   int tests  = 0;
   int fails  = 0;
   bit done   = 0;

   pow2_clk_divider uut (
      .clk_in(clk_in), .rst_n(rst_n), .sel(sel),
      .out_true(out_true), .out_comp(out_comp)
   );

   always #4 clk_in = ~clk_in;

   task automatic check_out(input logic exp_v, input string req);
      tests++;
      if (out_true !== {NP{exp_v}} || out_comp !== {NP{~exp_v}}) begin
         fails++;
         $display("FAIL %s: true=%b comp=%b expected true=%b comp=%b", req,
                  out_true, out_comp, {NP{exp_v}}, {NP{~exp_v}});
      end
   endtask

   function automatic logic expect_at(input logic [2:0] s, input int n, input bit high_phase);
      int k;
      if (!s[2]) return high_phase;           // R1 pass-through
      k = int'(s[1:0]) + 1;                    // divide by 2^k
      return ((n >> (k - 1)) & 1) == 0;        // R2 / R4 phase
   endfunction

   // Hold in reset, release just after a rising edge, check nsamp cycles
   task automatic run_case(input logic [2:0] s, input int nsamp);
      rst_n = 1'b0;
      sel = s;
      repeat (3) begin
         @(posedge clk_in); #2; check_out(1'b0, "R3 hold high phase");
         @(negedge clk_in); #2; check_out(1'b0, "R3 hold low phase");
      end
      @(posedge clk_in); #1;
      rst_n = 1'b1;
      #1; check_out(1'b0, "R5 no runt before falling edge");
      @(negedge clk_in); #2; check_out(1'b0, "R5 enable low phase");
      for (int n = 0; n < nsamp; n++) begin
         @(posedge clk_in); #2;
         check_out(expect_at(s, n, 1'b1), s[2] ? "R2 R4 R6 R7 divided high" : "R1 R6 R7 pass high");
         @(negedge clk_in); #2;
         check_out(expect_at(s, n, 1'b0), s[2] ? "R2 R4 R6 R7 divided low" : "R1 R6 R7 pass low");
      end
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      #3; check_out(1'b0, "R3 reset state");
      // Full sweep of every select code
      for (int s = 0; s < 8; s++) run_case(3'(s), 34);

      // R8: select change while running in divide-by-2 is ignored
      run_case(3'b100, 4);
      sel = 3'b000;
      for (int n = 4; n < 12; n++) begin
         @(posedge clk_in); #2; check_out(expect_at(3'b100, n, 1'b1), "R8 select ignored high");
         @(negedge clk_in); #2; check_out(expect_at(3'b100, n, 1'b0), "R8 select ignored low");
      end
      // New code through a reset cycle takes effect (R8, R1)
      run_case(3'b011, 6);

      // R3: asynchronous reset mid-run while a divided output is high
      run_case(3'b111, 3);
      @(posedge clk_in); #2; check_out(1'b1, "R2 div16 still high");
      rst_n = 1'b0;
      #1; check_out(1'b0, "R3 immediate reset divided");
      // R3: asynchronous reset in pass-through while the clock is high
      run_case(3'b001, 2);
      @(posedge clk_in); #2; check_out(1'b1, "R1 pass high");
      rst_n = 1'b0;
      #1; check_out(1'b0, "R3 immediate reset pass-through");

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule